// File: doc/BRIEF.md
# Bus Read Cycle Sequencer

This block steps a processor local bus through the clock states of one read transfer and produces the active-low read strobe that the addressed device uses to drive data. A read request, sampled together with a flag that picks memory or I/O space, starts a cycle in T1. The cycle then moves through T2 and T3, adds wait states for as long as the device holds its ready acknowledge low, and closes in T4. From T4 the block either goes back to idle or starts the next read at once.

The multiplexed address/data bus is released at the start of T2. The strobe is derived from that registered release indication, so it can never go low while the bus is still being driven with an address. A hold request from another bus master is granted only at a cycle boundary. While hold is granted, a registered output-enable tells the pad logic to put the strobe and the space-select status in high impedance. When hold ends, one dead clock follows before any new transfer or grant.

Top module: `rdseq_read_seq`

## Requirements
- R1: After reset the state code is idle (0), `rd_n_o` is 1, `addr_float_o` is 0, `hlda_o` is 0 and `strobe_oe_o` is 1.
- R2: A read request sampled at a boundary enters T1 (code 1) on that edge. Then T2 (2), T3 (3) and T4 (5) follow one per clock when `rdy_i` is high in T3. With no further request, idle (0) follows T4.
- R3: Each clock edge at which `rdy_i` is low while the state is T3 or TW enters (or stays in) TW (code 4). The first edge with `rdy_i` high moves to T4.
- R4: `rd_n_o` is 0 exactly in T2, T3 and TW. It is 1 in idle, T1, T4, hold (6) and gap (7).
- R5: `rd_n_o` is never 0 while `addr_float_o` is 0.
- R6: `addr_float_o` is 1 exactly in T2, T3, TW and T4.
- R7: `io_o` takes the value of `rd_io_i` (1 = I/O space, 0 = memory space) on the edge that enters T1. It holds that value until T4 ends, whatever `rd_io_i` does later.
- R8: A hold request is granted only at a boundary (idle, T4 or the end of gap). A request raised mid-cycle waits for T4 to end. At a boundary, hold takes priority over a pending read request.
- R9: While the state is hold (code 6), `hlda_o` is 1 and `strobe_oe_o` is 0. In every other state `hlda_o` is 0 and `strobe_oe_o` is 1.
- R10: When `hold_req_i` is low during hold, the next state is gap (7) for one clock even if a read is requested. A read request during gap then enters T1 on the following edge.
- R11: A read request present during T4 enters T1 directly on the next edge, with no idle clock between the two cycles.
- R12: `rdy_i` has no effect outside T3 and TW: a low `rdy_i` during T1 or T2 adds no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Request to start a read cycle |
| rd_io_i | input | 1 | Space select for the request: 1 I/O, 0 memory |
| rdy_i | input | 1 | Ready acknowledge from the device, active high, already synchronous |
| hold_req_i | input | 1 | Bus hold request from another master |
| tstate_o | output | 3 | Current state code: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4, 6 hold, 7 gap |
| rd_n_o | output | 1 | Read strobe, active low |
| io_o | output | 1 | Space select status of the running cycle |
| addr_float_o | output | 1 | Address bus released (float enable) |
| strobe_oe_o | output | 1 | Output enable for strobe and status; 0 means high impedance |
| hlda_o | output | 1 | Hold acknowledge |

## Verification
Every output is registered or decoded from registers. A decision taken from the inputs at one rising edge therefore shows on all outputs right after that same edge, and each result is due exactly one edge after its stimulus. The bench applies each cycle's inputs at the falling edge and, in the same step, queues the state and output values required after the next rising edge. A monitor takes one item per rising edge and compares it a moment after that edge. This also covers the one-clock gap after hold and the single wait state added per low ready sample.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6,
        ST_GAP  = 3'd7
    } tstate_e;

    typedef struct packed {
        logic float_en;
        logic io;
        logic hlda;
        logic oe;
    } drv_regs_t;

endpackage

// File: rtl/rdseq_hold_arb.sv
module rdseq_hold_arb
    import rdseq_pkg::*;
(
    input  tstate_e state_q,
    input  logic    gap_done,
    input  logic    hold_req,
    input  logic    rd_req,
    output logic    grant_hold,
    output logic    start_read
);

    logic at_boundary;

    always_comb begin
        at_boundary = (state_q == ST_IDLE) || (state_q == ST_T4) ||
                      ((state_q == ST_GAP) && gap_done);
        grant_hold  = at_boundary && hold_req;
        start_read  = at_boundary && !hold_req && rd_req;
    end

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import rdseq_pkg::*;
#(
    parameter int unsigned HOLD_GAP = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rdy,
    input  logic    hold_req,
    input  logic    grant_hold,
    input  logic    start_read,
    output tstate_e state_q,
    output tstate_e state_d,
    output logic    gap_done
);

    localparam int unsigned GW = (HOLD_GAP > 1) ? $clog2(HOLD_GAP) : 1;
    localparam logic [GW-1:0] GAP_LOAD = GW'(HOLD_GAP - 1);

    typedef struct packed {
        tstate_e       state;
        logic [GW-1:0] gap_cnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    assign state_q  = r_q.state;
    assign state_d  = r_d.state;
    assign gap_done = (r_q.gap_cnt == '0);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_T4: begin
                if (grant_hold)      r_d.state = ST_HOLD;
                else if (start_read) r_d.state = ST_T1;
                else                 r_d.state = ST_IDLE;
            end
            ST_GAP: begin
                if (!gap_done)       r_d.gap_cnt = r_q.gap_cnt - 1'b1;
                else if (grant_hold) r_d.state   = ST_HOLD;
                else if (start_read) r_d.state   = ST_T1;
                else                 r_d.state   = ST_IDLE;
            end
            ST_T1: r_d.state = ST_T2;
            ST_T2: r_d.state = ST_T3;
            ST_T3, ST_TW: r_d.state = rdy ? ST_T4 : ST_TW;
            ST_HOLD: begin
                if (!hold_req) begin
                    r_d.state   = ST_GAP;
                    r_d.gap_cnt = GAP_LOAD;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.gap_cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/rdseq_drive.sv
module rdseq_drive
    import rdseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  tstate_e state_q,
    input  tstate_e state_d,
    input  logic    rd_io,
    output logic    rd_n,
    output logic    io,
    output logic    float_en,
    output logic    hlda,
    output logic    oe
);

    drv_regs_t d_d, d_q;
    logic      strobe_phase;

    always_comb begin
        d_d          = d_q;
        d_d.float_en = (state_d == ST_T2) || (state_d == ST_T3) ||
                       (state_d == ST_TW) || (state_d == ST_T4);
        if (state_d == ST_T1) d_d.io = rd_io;
        d_d.hlda     = (state_d == ST_HOLD);
        d_d.oe       = (state_d != ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.float_en <= 1'b0;
            d_q.io       <= 1'b0;
            d_q.hlda     <= 1'b0;
            d_q.oe       <= 1'b1;
        end else begin
            d_q <= d_d;
        end
    end

    // strobe goes low only once the registered release indication is set
    always_comb begin
        strobe_phase = (state_q == ST_T2) || (state_q == ST_T3) ||
                       (state_q == ST_TW);
        rd_n         = !(d_q.float_en && strobe_phase);
    end

    assign io       = d_q.io;
    assign float_en = d_q.float_en;
    assign hlda     = d_q.hlda;
    assign oe       = d_q.oe;

endmodule

// File: rtl/rdseq_read_seq.sv
module rdseq_read_seq
    import rdseq_pkg::*;
#(
    parameter int unsigned HOLD_GAP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req_i,
    input  logic       rd_io_i,
    input  logic       rdy_i,
    input  logic       hold_req_i,
    output logic [2:0] tstate_o,
    output logic       rd_n_o,
    output logic       io_o,
    output logic       addr_float_o,
    output logic       strobe_oe_o,
    output logic       hlda_o
);

    tstate_e state_q, state_d;
    logic    gap_done, grant_hold, start_read;

    rdseq_hold_arb u_arb (
        .state_q    (state_q),
        .gap_done   (gap_done),
        .hold_req   (hold_req_i),
        .rd_req     (rd_req_i),
        .grant_hold (grant_hold),
        .start_read (start_read)
    );

    rdseq_fsm #(.HOLD_GAP(HOLD_GAP)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy        (rdy_i),
        .hold_req   (hold_req_i),
        .grant_hold (grant_hold),
        .start_read (start_read),
        .state_q    (state_q),
        .state_d    (state_d),
        .gap_done   (gap_done)
    );

    rdseq_drive u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .state_d  (state_d),
        .rd_io    (rd_io_i),
        .rd_n     (rd_n_o),
        .io       (io_o),
        .float_en (addr_float_o),
        .hlda     (hlda_o),
        .oe       (strobe_oe_o)
    );

    assign tstate_o = state_q;

endmodule

// File: rtl/rdseq_read_seq_chk.sv
module rdseq_read_seq_chk
    import rdseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rdy_i,
    input logic [2:0] tstate_o,
    input logic       rd_n_o,
    input logic       io_o,
    input logic       addr_float_o,
    input logic       strobe_oe_o,
    input logic       hlda_o
);

    // R2
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == ST_T1) |=> (tstate_o == ST_T2));

    // R3
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate_o == ST_T3) && !rdy_i) |=> (tstate_o == ST_TW));

    // R4
    strobe_off_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == ST_T4) |-> rd_n_o);

    // R5
    strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> addr_float_o);

    // R7
    space_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate_o == ST_T2) || (tstate_o == ST_T3) ||
         (tstate_o == ST_TW) || (tstate_o == ST_T4)) |-> $stable(io_o));

    // R8
    grant_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda_o) |-> (($past(tstate_o) == ST_IDLE) ||
                           ($past(tstate_o) == ST_T4) ||
                           ($past(tstate_o) == ST_GAP)));

    // R9
    hold_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> !strobe_oe_o);

    // R10
    hold_exit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_o) |-> (tstate_o == ST_GAP));

endmodule

bind rdseq_read_seq rdseq_read_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rdy_i        (rdy_i),
    .tstate_o     (tstate_o),
    .rd_n_o       (rd_n_o),
    .io_o         (io_o),
    .addr_float_o (addr_float_o),
    .strobe_oe_o  (strobe_oe_o),
    .hlda_o       (hlda_o)
);

// File: tb/rdseq_read_seq_test.sv
module rdseq_read_seq_test;
    import rdseq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req_i = 1'b0, rd_io_i = 1'b0, rdy_i = 1'b0, hold_req_i = 1'b0;
    logic [2:0] tstate_o;
    logic       rd_n_o, io_o, addr_float_o, strobe_oe_o, hlda_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [2:0] st;
        logic       io_chk;
        logic       io;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rdseq_read_seq uut (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .rd_io_i(rd_io_i),
        .rdy_i(rdy_i), .hold_req_i(hold_req_i), .tstate_o(tstate_o),
        .rd_n_o(rd_n_o), .io_o(io_o), .addr_float_o(addr_float_o),
        .strobe_oe_o(strobe_oe_o), .hlda_o(hlda_o)
    );

    // expected outputs derived from the state code per R4, R6, R9
    function automatic logic [6:0] expect_vec(input logic [2:0] st);
        logic rdn, flt, hl;
        rdn = !((st == ST_T2) || (st == ST_T3) || (st == ST_TW));
        flt = (st == ST_T2) || (st == ST_T3) || (st == ST_TW) || (st == ST_T4);
        hl  = (st == ST_HOLD);
        return {st, rdn, flt, hl, !hl};
    endfunction

    task automatic cyc(input logic rd, input logic sp, input logic rdy,
                       input logic hold, input logic [2:0] st,
                       input logic chk, input logic eio, input string req);
        exp_t e;
        @(negedge clk);
        rd_req_i = rd; rd_io_i = sp; rdy_i = rdy; hold_req_i = hold;
        e.st = st; e.io_chk = chk; e.io = eio; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: one queued item per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [6:0] act, ex;
                e   = exp_q.pop_front();
                act = {tstate_o, rd_n_o, addr_float_o, hlda_o, strobe_oe_o};
                ex  = expect_vec(e.st);
                n_cmp++;
                if (act !== ex || (e.io_chk && io_o !== e.io)) begin
                    n_bad++;
                    $display("FAIL %s: act st/rdn/flt/hlda/oe=%b io=%b exp=%b io=%b",
                             e.req, act, io_o, ex, e.io);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*5000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: outputs while in reset
        n_cmp++;
        if ({tstate_o, rd_n_o, addr_float_o, hlda_o, strobe_oe_o} !== 7'b000_1001) begin
            n_bad++;
            $display("FAIL R1: act=%b exp=%b",
                     {tstate_o, rd_n_o, addr_float_o, hlda_o, strobe_oe_o}, 7'b000_1001);
        end
        rst_n = 1'b1;

        // plain memory read
        cyc(1,0,1,0, ST_T1,   1,0, "R2");
        cyc(0,0,1,0, ST_T2,   1,0, "R5");
        cyc(0,0,1,0, ST_T3,   1,0, "R4");
        cyc(0,0,1,0, ST_T4,   1,0, "R6");
        cyc(0,0,1,0, ST_IDLE, 0,0, "R2");

        // I/O read with two wait states; space input changes after T1
        cyc(1,1,1,0, ST_T1,   1,1, "R7");
        cyc(0,0,1,0, ST_T2,   1,1, "R7");
        cyc(0,0,1,0, ST_T3,   1,1, "R7");
        cyc(0,0,0,0, ST_TW,   1,1, "R3");
        cyc(0,0,0,0, ST_TW,   1,1, "R3");
        cyc(0,0,1,0, ST_T4,   1,1, "R3");
        cyc(0,0,1,0, ST_IDLE, 0,0, "R2");

        // low ready outside T3, then back-to-back cycles
        cyc(1,0,0,0, ST_T1,   1,0, "R12");
        cyc(0,1,0,0, ST_T2,   1,0, "R12");
        cyc(0,1,0,0, ST_T3,   1,0, "R12");
        cyc(0,0,1,0, ST_T4,   1,0, "R12");
        cyc(1,1,1,0, ST_T1,   1,1, "R11");
        cyc(0,0,1,0, ST_T2,   1,1, "R11");
        cyc(0,0,1,0, ST_T3,   1,1, "R11");
        cyc(0,0,1,0, ST_T4,   1,1, "R11");
        cyc(0,0,1,0, ST_IDLE, 0,0, "R11");

        // hold raised mid-cycle, competing with a pending read
        cyc(1,0,1,0, ST_T1,   1,0, "R8");
        cyc(0,0,1,1, ST_T2,   1,0, "R8");
        cyc(0,0,1,1, ST_T3,   1,0, "R8");
        cyc(1,0,1,1, ST_T4,   1,0, "R8");
        cyc(1,0,1,1, ST_HOLD, 0,0, "R8");
        cyc(1,0,0,1, ST_HOLD, 0,0, "R9");
        cyc(1,1,1,0, ST_GAP,  0,0, "R10");
        cyc(1,1,1,0, ST_T1,   1,1, "R10");
        cyc(0,0,1,0, ST_T2,   1,1, "R10");
        cyc(0,0,1,0, ST_T3,   1,1, "R10");
        cyc(0,0,1,0, ST_T4,   1,1, "R10");
        cyc(0,0,1,0, ST_IDLE, 0,0, "R10");

        // hold from idle
        cyc(0,0,1,1, ST_HOLD, 0,0, "R8");
        cyc(0,0,1,1, ST_HOLD, 0,0, "R9");
        cyc(0,0,1,0, ST_GAP,  0,0, "R10");
        cyc(0,0,1,0, ST_IDLE, 0,0, "R10");

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule